// File: doc/BRIEF.md
# Interrupt Expander

This block gathers sixteen external interrupt request lines into one active-high, level-sensitive interrupt for a host processor. Each line first passes through a two-flop synchronizer. A latched pending bit records that the line was seen high. A per-line enable bit decides whether that pending bit may drive the combined output. The output stays high while any line is both pending and enabled.

Software reaches the block over a small 16-bit register bus with address, write enable, read enable, write data and read data. Writes take effect on the rising clock edge. Read data is combinational and is valid while read enable is high. The enable mask is never written directly. One address turns on the lines whose data bits are 1, and another address turns off the lines whose data bits are 1, so no read-modify-write is needed. Pending bits are acknowledged by writing ones to the pending register. A separate address returns the synchronized live input levels.

To bring the block up, software writes 0xFFFF to the disable address and then 0xFFFF to the pending register. After those two writes every line is disabled and nothing is pending.

Top module: `irq_expander`

## Requirements
- R1: After reset the enable mask and all pending bits are 0, every register reads 0 and `irqOut` is low.
- R2: `irqOut` is high exactly when at least one line has both its pending bit and its enable bit set; when the enable mask is 0, `irqOut` is low whatever is pending.
- R3: A write to byte offset 0x1A sets the enable bit of every line whose data bit is 1 and leaves the other lines unchanged; a read of 0x1A returns the enable mask (1 = enabled, bit n = line n).
- R4: A write to byte offset 0x1C clears the enable bit of every line whose data bit is 1 and leaves the other lines unchanged; a read of 0x1C returns 0.
- R5: A write to byte offset 0x16 clears the pending bit of every line whose data bit is 1; zero data bits leave their pending bits unchanged.
- R6: A line that is high after synchronization sets its pending bit, and the bit stays set after the line falls until it is acknowledged; if an acknowledge arrives while the line is still high, the bit stays set.
- R7: A read of byte offset 0x18 returns the synchronized input levels (bit n = line n), whatever the mask and pending state; a change at a line input shows there after two clock edges.
- R8: Reads of any offset other than 0x16, 0x18 and 0x1A return 0; writes to 0x18 or to any unmapped offset change nothing.
- R9: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with all lines low, leaves the mask 0, nothing pending and `irqOut` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read enable |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, 0 when no mapped register is read |
| lineIn | input | 16 | External interrupt request lines, asynchronous |
| irqOut | output | 1 | Combined level interrupt to the host |

## Verification
On every cycle, the assertions check four things. A mask-set write enables every selected line. A mask-clear write disables every selected line. The mask holds still unless one of those two strobes fires. A pending bit can rise only where the synchronized input was high. They also check that an acknowledge clears every selected bit whose line is low, and that at most one write strobe is decoded at a time. Some behaviour only the bench's scenarios can show. This includes the register read values, the two-edge latency of the live view, and a bit that stays latched after its line falls. It also includes the set-wins case for a line held high during acknowledge, the ignored writes to the live-status and unmapped offsets, and the bring-up sequence.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  // register byte offsets decoded by software
  localparam int OFS_PEND = 'h16;
  localparam int OFS_LIVE = 'h18;
  localparam int OFS_MSET = 'h1A;
  localparam int OFS_MCLR = 'h1C;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_LIVE = 2'd2,
    SEL_MASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   pendAck;
    logic   maskSet;
    logic   maskClr;
    rdSel_e rdSel;
  } regStb_t;

endpackage

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
  import irqx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStb_t           stb
);

  logic hitPend, hitLive, hitMset, hitMclr;

  always_comb begin
    hitPend = (busAddr == ADDR_W'(OFS_PEND));
    hitLive = (busAddr == ADDR_W'(OFS_LIVE));
    hitMset = (busAddr == ADDR_W'(OFS_MSET));
    hitMclr = (busAddr == ADDR_W'(OFS_MCLR));
  end

  always_comb begin
    stb.pendAck = busWrEn && hitPend;
    stb.maskSet = busWrEn && hitMset;
    stb.maskClr = busWrEn && hitMclr;
    stb.rdSel   = SEL_NONE;
    if (busRdEn) begin
      if (hitPend)      stb.rdSel = SEL_PEND;
      else if (hitLive) stb.rdSel = SEL_LIVE;
      else if (hitMset) stb.rdSel = SEL_MASK;
    end
  end

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0({stb.pendAck, stb.maskSet, stb.maskClr})); // R8
  end

endmodule

// File: rtl/irqx_datapath.sv
module irqx_datapath
  import irqx_pkg::*;
#(
  parameter int LINES       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  regStb_t          stb,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] rdData,
  output logic             irqOut
);

  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] syncLvl;
  logic [LINES-1:0] pending;
  logic [LINES-1:0] enMask;

  // input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= lineIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end
  assign syncLvl = syncQ[SYNC_STAGES-1];

  // per-line pending latch: set beats acknowledge
  for (genvar n = 0; n < LINES; n++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending[n] <= 1'b0;
      else if (syncLvl[n]) pending[n] <= 1'b1;
      else if (stb.pendAck && wrData[n]) pending[n] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enMask <= '0;
    else if (stb.maskSet) enMask <= enMask | wrData;
    else if (stb.maskClr) enMask <= enMask & ~wrData;
  end

  assign irqOut = |(pending & enMask);

  always_comb begin
    unique case (stb.rdSel)
      SEL_PEND: rdData = pending;
      SEL_LIVE: rdData = syncLvl;
      SEL_MASK: rdData = enMask;
      default:  rdData = '0;
    endcase
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.maskSet |=> ((enMask & $past(wrData)) == $past(wrData))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stb.maskClr |=> ((enMask & $past(wrData)) == '0)); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.maskSet || stb.maskClr) |=> $stable(enMask)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pendAck |=> ((pending & $past(wrData) & ~$past(syncLvl)) == '0)); // R5
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(syncLvl)) == '0)); // R6
  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enMask == '0) |-> !irqOut); // R2

endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irqx_pkg::*;
#(
  parameter int LINES       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [LINES-1:0]  busWrData,
  output logic [LINES-1:0]  busRdData,
  input  logic [LINES-1:0]  lineIn,
  output logic              irqOut
);

  regStb_t stb;

  irqx_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb)
  );

  irqx_datapath #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wrData (busWrData),
    .lineIn (lineIn),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/irq_expander_tb_top.sv
`timescale 1ns/100ps
module irq_expander_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [15:0] lineIn = '0;
  logic        irqOut;

  always #2.5 clk = ~clk;

  irq_expander dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .lineIn(lineIn), .irqOut(irqOut)
  );

  typedef struct {
    bit          isIrq;
    logic [7:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    probeIrq = 1'b0;
  bit    done = 1'b0;

  // monitor: compares outputs just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if ((busRdEn || probeIrq) && expQ.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {15'd0, irqOut} : busRdData;
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back('{1'b0, a, e, tag});
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(negedge clk);
    probeIrq = 1'b1;
    expQ.push_back('{1'b1, 8'h00, {15'd0, e}, tag});
    @(negedge clk);
    probeIrq = 1'b0;
  endtask

  task automatic setLines(input logic [15:0] v);
    @(negedge clk);
    lineIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h16, 16'h0000, "R1 pending after reset");
    rd(8'h18, 16'h0000, "R1 live after reset");
    rd(8'h1A, 16'h0000, "R1 mask after reset");
    chkIrq(1'b0, "R1 irq after reset");
    // R9 bring-up sequence
    wr(8'h1C, 16'hFFFF);
    wr(8'h16, 16'hFFFF);
    rd(8'h1A, 16'h0000, "R9 mask after init");
    rd(8'h16, 16'h0000, "R9 pending after init");
    chkIrq(1'b0, "R9 irq after init");
    // R7 live latency: two edges after a change
    @(negedge clk); lineIn = 16'h0401;
    rd(8'h18, 16'h0000, "R7 live one edge after change");
    rd(8'h18, 16'h0401, "R7 live after sync");
    rd(8'h16, 16'h0401, "R6 pending latched");
    chkIrq(1'b0, "R2 pending but masked");
    // R3 mask set
    wr(8'h1A, 16'h0400);
    rd(8'h1A, 16'h0400, "R3 mask after set");
    chkIrq(1'b1, "R2 pending and enabled");
    // R6 latch holds after line drops
    setLines(16'h0000);
    rd(8'h18, 16'h0000, "R7 live low");
    rd(8'h16, 16'h0401, "R6 pending held after line low");
    // R5 ack, zero bits no effect
    wr(8'h16, 16'h0001);
    rd(8'h16, 16'h0400, "R5 ack bit0 only");
    chkIrq(1'b1, "R2 still enabled pending");
    wr(8'h16, 16'h0400);
    rd(8'h16, 16'h0000, "R5 ack bit10");
    chkIrq(1'b0, "R2 nothing pending");
    // R6 set wins over ack while line high
    setLines(16'h8000);
    wr(8'h1A, 16'h8001);
    rd(8'h1A, 16'h8401, "R3 mask accumulates");
    wr(8'h16, 16'h8000);
    rd(8'h16, 16'h8000, "R6 set wins over ack");
    chkIrq(1'b1, "R2 line15 enabled");
    // R4 mask clear
    wr(8'h1C, 16'h8000);
    rd(8'h1A, 16'h0401, "R4 mask after clear");
    chkIrq(1'b0, "R2 pending but disabled");
    rd(8'h1C, 16'h0000, "R4 clear address reads zero");
    // R8 ignored writes and unmapped reads
    wr(8'h18, 16'hFFFF);
    wr(8'h00, 16'hFFFF);
    wr(8'h17, 16'hFFFF);
    wr(8'h1E, 16'h0000);
    rd(8'h1A, 16'h0401, "R8 mask unchanged by stray writes");
    rd(8'h16, 16'h8000, "R8 pending unchanged by stray writes");
    rd(8'h00, 16'h0000, "R8 unmapped read 0x00");
    rd(8'h17, 16'h0000, "R8 unmapped read 0x17");
    rd(8'h1E, 16'h0000, "R8 unmapped read 0x1E");
    // R7 live view independent of mask
    setLines(16'h5A5A);
    rd(8'h18, 16'h5A5A, "R7 live pattern");
    rd(8'h16, 16'hDA5A, "R6 pending pattern");
    chkIrq(1'b0, "R2 enabled lines 0 and 10 not pending");
    wr(8'h1A, 16'h0002);
    chkIrq(1'b1, "R2 line1 enabled");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard residue actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule